// File: doc/BRIEF.md
# Multi-Channel PWM Enable Controller

This block produces eight 8-bit pulse-width waveforms from one free-running prescaler. Each channel has its own enable bit, period register and duty register. Adjacent channels can be joined into one 16-bit channel. A small register write/read port gives access to all settings at any time.

An enable bit takes effect on the channel's output path as soon as it is written. The waveform itself begins only on the next pulse of the channel's clock source. The clock source is a pulse taken from a selectable tap of the prescaler. When a pair is joined, only the odd (low-order) channel's enable bit matters, and the even (high-order) output is held low. When every enable bit is clear, the prescaler stops and keeps its count.

Top module: `pwm_enable_ctrl`

## Requirements
- R1: After reset, every register reads 0, the prescaler reads 0 and all eight outputs are 0.
- R2: The registers can be written and read back at any time. The address map is:
  - 0: enables, bit n for channel n.
  - 1: join bits in bits [3:0], bit p joining channels 2p and 2p+1.
  - 2: tap for channels 0–3 in bits [2:0].
  - 3: tap for channels 4–7 in bits [2:0].
  - 4: prescaler, read-only.
  - 8+n: period of channel n.
  - 16+n: duty of channel n.
  - Unused bits and unused addresses read 0.
- R3: The 8-bit prescaler increments on every clock while any enable bit is set. It holds its value while all enable bits are clear.
- R4: A channel's clock-source pulse is high in a cycle when the prescaler is running and its low `tap` bits are all ones. Tap 0 gives a pulse on every cycle.
- R5: After an enable bit is set, the output stays 0 until the first clock-source pulse. On that pulse the channel counter starts at 0.
- R6: An active 8-bit channel advances its counter on each clock-source pulse and wraps to 0 after period−1. Its output is 1 while counter < duty.
- R7: Once an enable bit is clear, the channel's output is 0 from the next clock, and its counter returns to 0.
- R8: A joined pair p uses the enable of channel 2p+1 only. It counts in 16 bits against {period 2p, period 2p+1} and {duty 2p, duty 2p+1}, with the even register as the high byte. The waveform appears on output 2p+1.
- R9: While pair p is joined, output 2p stays 0 and the enable bit of channel 2p has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| pwm_out | output | 8 | Waveform outputs, bit n for channel n |

## Verification
The bench enables channels at arbitrary prescaler phases with taps greater than zero. A design that did not wait for the clock-source pulse would then raise its output a few cycles early. It also sets only the even enable bit of a joined pair: a design that still honoured that bit would start an output. Clearing all enables and then watching the prescaler readback catches a counter that keeps running or resets instead of holding. A 16-bit period longer than 256 catches a joined channel that wraps at eight bits or swaps the register bytes.

// File: rtl/pwm_enable_ctrl.sv
module pwm_enable_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [4:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [7:0] pwm_out
);
  localparam int NCH   = 8;
  localparam int NPAIR = NCH / 2;

  logic [NCH-1:0]   en_q;
  logic [NPAIR-1:0] cat_q;
  logic [2:0]       tap_lo_q, tap_hi_q;
  logic [7:0]       presc_q;
  logic [7:0]       per_q  [NCH];
  logic [7:0]       duty_q [NCH];
  logic             run, tick_lo, tick_hi;
  logic [7:0]       mask_lo, mask_hi;

  assign run     = |en_q;
  assign mask_lo = ~(8'hFF << tap_lo_q);
  assign mask_hi = ~(8'hFF << tap_hi_q);
  assign tick_lo = run && ((presc_q & mask_lo) == mask_lo);
  assign tick_hi = run && ((presc_q & mask_hi) == mask_hi);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q     <= '0;
      cat_q    <= '0;
      tap_lo_q <= '0;
      tap_hi_q <= '0;
      presc_q  <= '0;
      for (int i = 0; i < NCH; i++) begin
        per_q[i]  <= '0;
        duty_q[i] <= '0;
      end
    end else begin
      if (run) presc_q <= presc_q + 8'd1;
      if (wr_en) begin
        case (wr_addr[4:3])
          2'b00:
            case (wr_addr[2:0])
              3'd0:    en_q     <= wr_data;
              3'd1:    cat_q    <= wr_data[NPAIR-1:0];
              3'd2:    tap_lo_q <= wr_data[2:0];
              3'd3:    tap_hi_q <= wr_data[2:0];
              default: ;
            endcase
          2'b01:   per_q[wr_addr[2:0]]  <= wr_data;
          2'b10:   duty_q[wr_addr[2:0]] <= wr_data;
          default: ;
        endcase
      end
    end

  always_comb begin
    rd_data = '0;
    case (rd_addr[4:3])
      2'b00:
        case (rd_addr[2:0])
          3'd0:    rd_data = en_q;
          3'd1:    rd_data = {4'b0, cat_q};
          3'd2:    rd_data = {5'b0, tap_lo_q};
          3'd3:    rd_data = {5'b0, tap_hi_q};
          3'd4:    rd_data = presc_q;
          default: rd_data = '0;
        endcase
      2'b01:   rd_data = per_q[rd_addr[2:0]];
      2'b10:   rd_data = duty_q[rd_addr[2:0]];
      default: rd_data = '0;
    endcase
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int HI = 2 * p;
    localparam int LO = 2 * p + 1;
    logic        tick, joined, act_lo, act_hi;
    logic [15:0] cnt, per16, duty16;
    logic [16:0] nxt16;
    logic [8:0]  nxt_lo, nxt_hi;

    assign tick   = (p < NPAIR / 2) ? tick_lo : tick_hi;
    assign joined = cat_q[p];
    assign per16  = {per_q[HI], per_q[LO]};
    assign duty16 = {duty_q[HI], duty_q[LO]};
    assign nxt16  = {1'b0, cnt} + 17'd1;
    assign nxt_lo = {1'b0, cnt[7:0]} + 9'd1;
    assign nxt_hi = {1'b0, cnt[15:8]} + 9'd1;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        act_lo <= 1'b0;
        act_hi <= 1'b0;
        cnt    <= '0;
      end else begin
        if (!en_q[LO]) begin
          act_lo   <= 1'b0;
          cnt[7:0] <= '0;
          if (joined) cnt[15:8] <= '0;
        end else if (tick) begin
          if (!act_lo) begin
            act_lo   <= 1'b1;
            cnt[7:0] <= '0;
            if (joined) cnt[15:8] <= '0;
          end else if (joined)
            cnt <= (nxt16 >= {1'b0, per16}) ? '0 : nxt16[15:0];
          else
            cnt[7:0] <= (nxt_lo >= {1'b0, per_q[LO]}) ? '0 : nxt_lo[7:0];
        end
        if (joined || !en_q[HI]) begin
          act_hi <= 1'b0;
          if (!joined) cnt[15:8] <= '0;
        end else if (tick) begin
          if (!act_hi) begin
            act_hi    <= 1'b1;
            cnt[15:8] <= '0;
          end else
            cnt[15:8] <= (nxt_hi >= {1'b0, per_q[HI]}) ? '0 : nxt_hi[7:0];
        end
      end

    assign pwm_out[LO] = act_lo && (joined ? (cnt < duty16) : (cnt[7:0] < duty_q[LO]));
    assign pwm_out[HI] = !joined && act_hi && (cnt[15:8] < duty_q[HI]);
  end
endmodule

module pwm_enable_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] en,
  input logic [3:0] cat,
  input logic [7:0] presc,
  input logic       tick_lo,
  input logic       tick_hi,
  input logic [7:0] pwm_out
);
  logic [7:0] hi_mask;
  assign hi_mask = {1'b0, cat[3], 1'b0, cat[2], 1'b0, cat[1], 1'b0, cat[0]};

  assert_presc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 8'h0) |=> $stable(presc));

  assert_presc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en != 8'h0) |=> (presc == $past(presc) + 8'd1));

  assert_joined_even_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & hi_mask) == 8'h0);

  assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~$past(en)) == 8'h0);

  assert_rise_lo_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((pwm_out[3:0] & ~$past(pwm_out[3:0])) != 4'h0) && !$past(wr_en)) |-> $past(tick_lo));

  assert_rise_hi_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((pwm_out[7:4] & ~$past(pwm_out[7:4])) != 4'h0) && !$past(wr_en)) |-> $past(tick_hi));
endmodule

bind pwm_enable_ctrl pwm_enable_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .en(en_q), .cat(cat_q),
  .presc(presc_q), .tick_lo(tick_lo), .tick_hi(tick_hi), .pwm_out(pwm_out)
);

// File: tb/pwm_enable_ctrl_tb.sv
`timescale 1ns/1ps
module pwm_enable_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_addr = 5'd4;
  logic [7:0] rd_data;
  logic [7:0] pwm_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int m_en, m_cat, m_tapa, m_tapb, m_presc;
  int m_per[8], m_duty[8], m_act[8], m_cnt[8];

  always #2 clk = ~clk;

  pwm_enable_ctrl dut_i (.*);

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mread(int a);
    if (a == 0) return m_en;
    if (a == 1) return m_cat;
    if (a == 2) return m_tapa;
    if (a == 3) return m_tapb;
    if (a == 4) return m_presc;
    if (a >= 8 && a < 16) return m_per[a-8];
    if (a >= 16 && a < 24) return m_duty[a-16];
    return 0;
  endfunction

  function automatic int mout(int i);
    int j;
    j = (m_cat >> (i / 2)) & 1;
    if (i % 2 == 0) return int'(!j && m_act[i] != 0 && m_cnt[i] < m_duty[i]);
    if (j != 0)
      return int'(m_act[i] != 0 &&
        (m_cnt[i-1] * 256 + m_cnt[i]) < (m_duty[i-1] * 256 + m_duty[i]));
    return int'(m_act[i] != 0 && m_cnt[i] < m_duty[i]);
  endfunction

  task automatic step();
    int an[8], cn[8];
    bit run;
    run = (m_en != 0);
    for (int i = 0; i < 8; i++) begin an[i] = m_act[i]; cn[i] = m_cnt[i]; end
    for (int p = 0; p < 4; p++) begin
      int tap, hi, lo, v;
      bit j, tk;
      tap = (p < 2) ? m_tapa : m_tapb;
      tk  = run && ((m_presc % (1 << tap)) == (1 << tap) - 1);
      hi = 2 * p; lo = 2 * p + 1;
      j = ((m_cat >> p) & 1) != 0;
      if (((m_en >> lo) & 1) == 0) begin
        an[lo] = 0; cn[lo] = 0; if (j) cn[hi] = 0;
      end else if (tk) begin
        if (m_act[lo] == 0) begin
          an[lo] = 1; cn[lo] = 0; if (j) cn[hi] = 0;
        end else if (j) begin
          v = m_cnt[hi] * 256 + m_cnt[lo] + 1;
          if (v >= m_per[hi] * 256 + m_per[lo]) v = 0;
          cn[hi] = v / 256; cn[lo] = v % 256;
        end else begin
          v = m_cnt[lo] + 1;
          if (v >= m_per[lo]) v = 0;
          cn[lo] = v;
        end
      end
      if (j || ((m_en >> hi) & 1) == 0) begin
        an[hi] = 0; if (!j) cn[hi] = 0;
      end else if (tk) begin
        if (m_act[hi] == 0) begin an[hi] = 1; cn[hi] = 0; end
        else begin
          v = m_cnt[hi] + 1;
          if (v >= m_per[hi]) v = 0;
          cn[hi] = v;
        end
      end
    end
    for (int i = 0; i < 8; i++) begin m_act[i] = an[i]; m_cnt[i] = cn[i]; end
    if (run) m_presc = (m_presc + 1) % 256;
    if (wr_en) begin
      int a, d;
      a = int'(wr_addr); d = int'(wr_data);
      if (a == 0) m_en = d;
      else if (a == 1) m_cat = d % 16;
      else if (a == 2) m_tapa = d % 8;
      else if (a == 3) m_tapb = d % 8;
      else if (a >= 8 && a < 16) m_per[a-8] = d;
      else if (a >= 16 && a < 24) m_duty[a-16] = d;
    end
  endtask

  always @(posedge clk) if (rst_n) step();

  always @(negedge clk) if (rst_n && !done) begin
    #1;
    check(int'(rd_data) == mread(int'(rd_addr)), (rd_addr == 5'd4) ? "R3" : "R2",
          int'(rd_data), mread(int'(rd_addr)));
    for (int i = 0; i < 8; i++) begin
      string tag;
      int tap;
      tap = (i < 4) ? m_tapa : m_tapb;
      if (i % 2 == 0 && ((m_cat >> (i / 2)) & 1) != 0) tag = "R9";
      else if (((m_cat >> (i / 2)) & 1) != 0) tag = "R8";
      else if (((m_en >> i) & 1) == 0) tag = "R7";
      else if (m_act[i] == 0) tag = "R5";
      else if (tap > 0) tag = "R4";
      else tag = "R6";
      check(int'(pwm_out[i]) == mout(i), tag, int'(pwm_out[i]), mout(i));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readback(int a);
    @(negedge clk);
    rd_addr = 5'(a);
    @(negedge clk);
    rd_addr = 5'd4;
  endtask

  initial begin
    m_en = 0; m_cat = 0; m_tapa = 0; m_tapb = 0; m_presc = 0;
    for (int i = 0; i < 8; i++) begin m_per[i] = 0; m_duty[i] = 0; m_act[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    check(pwm_out == 8'h0, "R1", int'(pwm_out), 0);
    check(rd_data == 8'h0, "R1", int'(rd_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    foreach (m_per[k]) readback(8 + k);
    readback(0); readback(1);
    idle(10);
    check(rd_data == 8'h0, "R3", int'(rd_data), 0);
    wr(2, 8'hFA); wr(3, 1);
    wr(8, 5);  wr(16, 2);
    wr(9, 4);  wr(17, 1);
    wr(12, 6); wr(20, 6);
    wr(13, 3); wr(21, 0);
    wr(14, 7); wr(22, 3);
    wr(15, 9); wr(23, 8);
    for (int a = 0; a < 24; a++) readback(a);
    wr(0, 8'h01); idle(60);
    wr(0, 8'h33); idle(150);
    wr(16, 4); idle(60);
    wr(0, 8'hF3); idle(120);
    wr(0, 8'hF2); idle(40);
    wr(0, 8'h00); idle(30);
    check(int'(rd_data) == m_presc, "R3", int'(rd_data), m_presc);
    wr(10, 1); wr(11, 2); wr(18, 0); wr(19, 100);
    wr(1, 8'h02); wr(2, 0);
    wr(0, 8'h04); idle(40);
    check(pwm_out == 8'h0, "R9", int'(pwm_out), 0);
    wr(0, 8'h0C); idle(700);
    wr(0, 8'h08); idle(300);
    wr(0, 8'h00); idle(10);
    wr(1, 0); wr(0, 8'h04); idle(20);
    readback(1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R6 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule